// File: doc/BRIEF.md
# Button-Stepped 8-bit Pseudo-Random Generator with Hex Display

This block holds an 8-bit linear-feedback shift register and advances it by one step each time a push button is pressed. The register shifts toward its least significant bit. The bit that enters at the top is the parity of bits 4, 3, 2 and 0 of the state before the step. Any nonzero seed walks through all 255 nonzero byte values before the sequence repeats.

The button is not used as a clock. It is brought into the system clock domain through a chain of flip-flops. A rising edge of the synchronized level then produces a single-cycle step enable. The all-zero state would otherwise never change, so the block detects it and leaves it on the next step. The state is given out raw, as two nibbles, and as two active-low seven-segment patterns that show the state in hexadecimal.

Top module: `lfsr_hex_gen`

## Requirements
- R1: While `rst_n` is low, the state is set to parameter `SEED` (default 8'h01). The synchronizer and the edge detector are cleared, so no step is pending when reset is released.
- R2: On a step, the state shifts right by one. New bits [6:0] equal the old bits [7:1], and the old bit 0 is dropped.
- R3: On a step, the new bit 7 is old bit 4 XOR bit 3 XOR bit 2 XOR bit 0. From 8'h01, the next six states are 80, 40, 20, 10, 88, C4 (hex).
- R4: The state changes only on a step. A button held high for any length of time produces exactly one step.
- R5: If the state is 8'h00 when a step occurs, the next state is 8'h01.
- R6: The step enable lasts one clock cycle. With `SYNC_STAGES` = N, the state changes at the (N+1)-th rising clock edge that samples `btn` high after a low period.
- R7: Starting from 8'h01, the state visits each of the 255 nonzero values exactly once, and it returns to 8'h01 on the 255th step.
- R8: `nib_hi` equals state[7:4] and `nib_lo` equals state[3:0].
- R9: `seg_hi_n` and `seg_lo_n` are active-low. Bit 0 is segment a and bit 6 is segment g. Hex digits 0 to F use these active-high gfedcba codes: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn | input | 1 | Raw push-button level, asynchronous |
| state_q | output | 8 | Current register state |
| nib_hi | output | 4 | Upper nibble of the state |
| nib_lo | output | 4 | Lower nibble of the state |
| seg_hi_n | output | 7 | Active-low segment pattern for the upper digit |
| seg_lo_n | output | 7 | Active-low segment pattern for the lower digit |

## Verification
The bench builds two copies of the block. The main copy uses the defaults: `SEED` = 8'h01 and `SYNC_STAGES` = 2. It runs the table of early states, a full 255-step period, and the press-to-update latency check. The second copy uses `SEED` = 8'h00 and `SYNC_STAGES` = 3. The zero seed is the only legal way to put the register into the lock-up state, so it lets the bench exercise the zero escape through the ports. The deeper chain checks that the latency follows the parameter.

// File: rtl/lfsr_hex_gen.sv
module lfsr_hex_gen #(
  parameter logic [7:0] SEED        = 8'h01,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn,
  output logic [7:0] state_q,
  output logic [3:0] nib_hi,
  output logic [3:0] nib_lo,
  output logic [6:0] seg_hi_n,
  output logic [6:0] seg_lo_n
);
  localparam int         SL       = SYNC_STAGES < 2 ? 2 : SYNC_STAGES;
  localparam logic [7:0] TAP_MASK = 8'b0001_1101;

  logic [SL-1:0] sync_q;
  logic          btn_prev;
  logic          step_pulse;
  logic          fb_bit;
  logic [7:0]    state_nx;

  function automatic logic [6:0] hex_seg(input logic [3:0] d);
    logic [6:0] on;
    case (d)
      4'h0: on = 7'h3F;  4'h1: on = 7'h06;  4'h2: on = 7'h5B;  4'h3: on = 7'h4F;
      4'h4: on = 7'h66;  4'h5: on = 7'h6D;  4'h6: on = 7'h7D;  4'h7: on = 7'h07;
      4'h8: on = 7'h7F;  4'h9: on = 7'h6F;  4'hA: on = 7'h77;  4'hB: on = 7'h7C;
      4'hC: on = 7'h39;  4'hD: on = 7'h5E;  4'hE: on = 7'h79;  default: on = 7'h71;
    endcase
    return ~on;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      btn_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SL-2:0], btn};
      btn_prev <= sync_q[SL-1];
    end
  end

  assign step_pulse = sync_q[SL-1] & ~btn_prev;
  assign fb_bit     = ^(state_q & TAP_MASK);
  assign state_nx   = (state_q == 8'h00) ? 8'h01 : {fb_bit, state_q[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= SEED;
    else if (step_pulse) state_q <= state_nx;
  end

  assign nib_hi   = state_q[7:4];
  assign nib_lo   = state_q[3:0];
  assign seg_hi_n = hex_seg(nib_hi);
  assign seg_lo_n = hex_seg(nib_lo);
endmodule

module lfsr_hex_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       step,
  input logic [7:0] state
);
  // R2
  shift_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && state != 8'h00) |=> state[6:0] == $past(state[7:1]));
  // R3
  feedback_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && state != 8'h00) |=> state[7] == ($past(state[4]) ^ $past(state[3]) ^ $past(state[2]) ^ $past(state[0])));
  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));
  // R5
  zero_escape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && state == 8'h00) |=> state == 8'h01);
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);
endmodule

bind lfsr_hex_gen lfsr_hex_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step(step_pulse), .state(state_q)
);

// File: tb/lfsr_hex_gen_bench.sv
module lfsr_hex_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn = 1'b0;
  logic btn_z = 1'b0;
  logic [7:0] st, st_z;
  logic [3:0] nh, nl, nh_z, nl_z;
  logic [6:0] sh, sl, sh_z, sl_z;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lfsr_hex_gen u_lfsr_hex_gen (.clk(clk), .rst_n(rst_n), .btn(btn), .state_q(st),
    .nib_hi(nh), .nib_lo(nl), .seg_hi_n(sh), .seg_lo_n(sl));

  lfsr_hex_gen #(.SEED(8'h00), .SYNC_STAGES(3)) u_lfsr_hex_gen_z (.clk(clk), .rst_n(rst_n),
    .btn(btn_z), .state_q(st_z), .nib_hi(nh_z), .nib_lo(nl_z), .seg_hi_n(sh_z), .seg_lo_n(sl_z));

  localparam logic [7:0] SEQ [6] = '{8'h80, 8'h40, 8'h20, 8'h10, 8'h88, 8'hC4};

  function automatic logic [7:0] model_next(input logic [7:0] s);
    if (s == 8'h00) return 8'h01;
    return {s[4] ^ s[3] ^ s[2] ^ s[0], s[7:1]};
  endfunction

  function automatic logic [6:0] model_seg(input logic [3:0] d);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return ~t[d];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic press(input int hold);
    @(negedge clk) btn = 1'b1;
    repeat (hold) @(negedge clk);
    btn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_display(input string req);
    check({req, " nib_hi"}, nh, st[7:4]);
    check({req, " nib_lo"}, nl, st[3:0]);
    check({req, " seg_hi"}, sh, model_seg(st[7:4]));
    check({req, " seg_lo"}, sl, model_seg(st[3:0]));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] exp;
    bit seen [256];
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset main", st, 8'h01);
    check("R1 reset zero-seed", st_z, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 no step after release", st, 8'h01);
    check_display("R9 R8 at seed");

    // R2 R3 vector table
    foreach (SEQ[i]) begin
      press(3);
      check("R3 R2 table", st, SEQ[i]);
      check_display("R9 R8 table");
    end

    // R4 long hold gives one step
    exp = model_next(st);
    press(40);
    check("R4 held button single step", st, exp);
    repeat (20) @(negedge clk);
    check("R4 idle hold", st, exp);

    // R6 latency with 2 stages
    @(negedge clk) btn = 1'b1;
    exp = st;
    repeat (2) @(posedge clk);
    #1 check("R6 not yet updated", st, exp);
    @(posedge clk);
    #1 check("R6 updated at edge N+1", st, model_next(exp));
    @(negedge clk) btn = 1'b0;
    repeat (4) @(negedge clk);

    // R7 full period from 01
    rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    exp = 8'h01;
    for (int k = 1; k <= 255; k++) begin
      seen[st] = 1'b1;
      press(2);
      exp = model_next(exp);
      if (k < 255) begin
        if (st == 8'h00 || seen[st]) check("R7 repeated or zero", st, 8'hFF);
        if (st !== exp) check("R7 step", st, exp);
      end
      if (k % 64 == 0) check_display("R9 R8 walk");
    end
    check("R7 back to seed after 255", st, 8'h01);
    begin
      int cnt = 0;
      for (int v = 1; v < 256; v++) if (seen[v]) cnt++;
      check("R7 distinct count", cnt, 255);
    end

    // R5 zero escape on zero-seed copy, with R6 for 3 stages
    check("R9 zero digits", sh_z, 7'h40);
    @(negedge clk) btn_z = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R6 three-stage not yet", st_z, 8'h00);
    @(posedge clk);
    #1 check("R5 zero escapes to 01", st_z, 8'h01);
    @(negedge clk) btn_z = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 zero-seed nib_lo", nl_z, 4'h1);
    check("R9 zero-seed seg_lo", sl_z, model_seg(4'h1));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule